// File: doc/BRIEF.md
# Floating-Point Error Freeze and Reporting Controller

This controller sits next to a floating-point execution unit. It keeps sticky exception flags and puts them against per-exception mask bits. It also runs the legacy error-reporting path. An unmasked exception drives an active-low error pin so that an external interrupt can be requested. Issue then stalls at the next waiting floating-point or WAIT instruction, and stays stalled until the core accepts an interrupt. The arithmetic, the interrupt controller and the handler software all sit outside this block.

Each exception has a timing bit that sets when its pin is raised. With the bit at 0, the pin is raised as soon as the exception is detected. With the bit at 1, the pin waits for the next waiting instruction. A no-wait instruction never stalls. When the numeric-error-mode bit is 0, an asserted ignore input makes the unit continue past a pending error. When the numeric-error-mode bit is 1, the pin stays quiet and a one-cycle internal trap pulse is raised at the stall point instead.

The freeze state machine has four states:
- RUN: normal issue.
- FROZEN: stalled and waiting for an interrupt.
- THAW: the one release cycle after the interrupt is accepted.
- TRAP: the one-cycle internal trap.

Its transitions are:
- RUN→FROZEN: a waiting issue finds a pending error while the numeric-error-mode bit is 0 and the ignore input is low.
- RUN→TRAP: a waiting issue finds a pending error while the numeric-error-mode bit is 1.
- FROZEN→THAW: an interrupt is accepted.
- THAW→RUN and TRAP→RUN: both always happen on the next clock.

Top module: `fpu_err_freeze_ctrl`

## Requirements
- R1: During and right after reset, `flags` is 0, `err_n` is 1, `freeze` is 0 and `trap` is 0.
- R2: A 1 on bit i of `exc_raise` sets flag i on the next clock edge. The flag stays set across later no-wait (class 1) and waiting (class 0) issues.
- R3: An accepted issue of class 2 (clear/init/save) zeroes every flag on the next edge. It takes precedence over a raise in the same cycle.
- R4: An accepted issue of class 3 (restore/load-environment) loads `flags` from `restore_flags` on the next edge. Later raises accumulate on top of the loaded value.
- R5: When every set flag has its mask bit at 1, `err_n` stays 1 and a waiting issue causes no freeze.
- R6: If a flag is set, its mask bit is 0, its timing bit is 0, `ne_mode` is 0 and `ignore_err` is 0, then `err_n` goes to 0 one edge after the flag becomes visible.
- R7: An unmasked flag whose timing bit is 1 leaves `err_n` at 1 until a waiting issue (class 0) is accepted. `err_n` is 0 after that edge.
- R8: If a waiting issue is accepted while any unmasked flag is set, with `ne_mode` 0 and `ignore_err` 0, then `freeze` is 1 after that edge.
- R9: A no-wait issue (class 1) never raises `freeze` or `trap`.
- R10: With `ne_mode` 0 and `ignore_err` 1, a waiting issue with an error pending causes no freeze, and `err_n` does not fall.
- R11: While frozen, issues are not accepted and `freeze` stays 1. If `irq_ack` is sampled at edge k, `freeze` is still 1 after k and is 0 after k+1.
- R12: After a clear or restore leaves no unmasked flag set, `err_n` returns to 1 on the following edge.
- R13: With `ne_mode` 1, `err_n` stays 1. A waiting issue with an error pending gives `trap`=1 for exactly one cycle after that edge, and `freeze` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_raise | input | NUM_EXC | Per-exception detection pulses |
| exc_mask | input | NUM_EXC | Mask bits; 1 masks the exception |
| err_timing | input | NUM_EXC | Per-exception pin timing: 0 = at detection, 1 = at next waiting issue |
| ne_mode | input | 1 | Numeric-error-mode bit; 1 selects the internal trap |
| ignore_err | input | 1 | Ignore-error input |
| issue_vld | input | 1 | Instruction issue strobe |
| issue_cls | input | 2 | Class: 0 waiting, 1 no-wait, 2 clear/init/save, 3 restore/load-env |
| restore_flags | input | NUM_EXC | Flag image for a restore issue |
| irq_ack | input | 1 | Interrupt-accepted pulse |
| flags | output | NUM_EXC | Sticky exception flags |
| err_n | output | 1 | Active-low error pin |
| freeze | output | 1 | Issue stall |
| trap | output | 1 | Internal trap pulse |

## Verification
Every output is registered. A flag change therefore shows one cycle after the raise or issue that caused it. An immediate error pin shows two cycles after the raise, because the flag must be set before the pin logic can see it. Freeze, trap and a deferred pin show one cycle after the waiting issue, and the freeze release shows two cycles after the interrupt pulse. The driver pushes each expected value into the scoreboard together with the cycle in which it is due. The monitor compares it on the falling edge of exactly that cycle, so every sample falls between register updates.

// File: rtl/fpu_err_pkg.sv
package fpu_err_pkg;

    typedef enum logic [1:0] {
        CLS_WAIT    = 2'd0,
        CLS_NOWAIT  = 2'd1,
        CLS_CLEAR   = 2'd2,
        CLS_RESTORE = 2'd3
    } issue_cls_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_THAW   = 2'd2,
        ST_TRAP   = 2'd3
    } frz_state_e;

endpackage

// File: rtl/fpu_flag_bank.sv
module fpu_flag_bank #(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] raise_i,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic [NUM_EXC-1:0] load_val_i,
    output logic [NUM_EXC-1:0] flags_o
);

    // One sticky cell per exception; load beats clear beats raise.
    for (genvar gi = 0; gi < NUM_EXC; gi++) begin : g_cell
        logic cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (load_i) begin
                cell_q <= load_val_i[gi];
            end else if (clear_i) begin
                cell_q <= 1'b0;
            end else if (raise_i[gi]) begin
                cell_q <= 1'b1;
            end
        end

        assign flags_o[gi] = cell_q;
    end

endmodule

// File: rtl/fpu_err_pin.sv
module fpu_err_pin #(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] flags_i,
    input  logic [NUM_EXC-1:0] mask_i,
    input  logic [NUM_EXC-1:0] timing_i,
    input  logic               ne_mode_i,
    input  logic               ignore_i,
    input  logic               wait_hit_i,
    output logic               pending_o,
    output logic               err_n_o
);

    logic [NUM_EXC-1:0] unmasked;
    logic               early_pend;
    logic               set_req;
    logic               err_q;

    always_comb begin
        unmasked   = flags_i & ~mask_i;
        pending_o  = |unmasked;
        early_pend = |(unmasked & ~timing_i);
        set_req    = !ne_mode_i && !ignore_i &&
                     (early_pend || (wait_hit_i && pending_o));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (ne_mode_i || !pending_o) begin
            err_q <= 1'b0;
        end else if (set_req) begin
            err_q <= 1'b1;
        end
    end

    assign err_n_o = ~err_q;

endmodule

// File: rtl/fpu_freeze_fsm.sv
module fpu_freeze_fsm
    import fpu_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_hit_i,
    input  logic pending_i,
    input  logic ne_mode_i,
    input  logic ignore_i,
    input  logic irq_ack_i,
    output logic run_o,
    output logic freeze_o,
    output logic trap_o
);

    frz_state_e state_q;
    frz_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wait_hit_i && pending_i) begin
                    if (ne_mode_i) begin
                        state_d = ST_TRAP;
                    end else if (!ignore_i) begin
                        state_d = ST_FROZEN;
                    end
                end
            end
            ST_FROZEN: begin
                if (irq_ack_i) begin
                    state_d = ST_THAW;
                end
            end
            ST_THAW: state_d = ST_RUN;
            ST_TRAP: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o    = 1'b0;
        freeze_o = 1'b0;
        trap_o   = 1'b0;
        unique case (state_q)
            ST_RUN:    run_o    = 1'b1;
            ST_FROZEN: freeze_o = 1'b1;
            ST_THAW:   freeze_o = 1'b1;
            ST_TRAP:   trap_o   = 1'b1;
            default:   run_o    = 1'b1;
        endcase
    end

endmodule

// File: rtl/fpu_err_freeze_ctrl.sv
module fpu_err_freeze_ctrl
    import fpu_err_pkg::*;
#(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_raise,
    input  logic [NUM_EXC-1:0] exc_mask,
    input  logic [NUM_EXC-1:0] err_timing,
    input  logic               ne_mode,
    input  logic               ignore_err,
    input  logic               issue_vld,
    input  logic [1:0]         issue_cls,
    input  logic [NUM_EXC-1:0] restore_flags,
    input  logic               irq_ack,
    output logic [NUM_EXC-1:0] flags,
    output logic               err_n,
    output logic               freeze,
    output logic               trap
);

    issue_cls_e cls;
    logic       run;
    logic       accept;
    logic       wait_hit;
    logic       clear_hit;
    logic       load_hit;
    logic       pending;

    always_comb begin
        cls       = issue_cls_e'(issue_cls);
        accept    = issue_vld && run;
        wait_hit  = accept && (cls == CLS_WAIT);
        clear_hit = accept && (cls == CLS_CLEAR);
        load_hit  = accept && (cls == CLS_RESTORE);
    end

    fpu_flag_bank #(.NUM_EXC(NUM_EXC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (exc_raise),
        .clear_i    (clear_hit),
        .load_i     (load_hit),
        .load_val_i (restore_flags),
        .flags_o    (flags)
    );

    fpu_err_pin #(.NUM_EXC(NUM_EXC)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flags),
        .mask_i     (exc_mask),
        .timing_i   (err_timing),
        .ne_mode_i  (ne_mode),
        .ignore_i   (ignore_err),
        .wait_hit_i (wait_hit),
        .pending_o  (pending),
        .err_n_o    (err_n)
    );

    fpu_freeze_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_hit_i (wait_hit),
        .pending_i  (pending),
        .ne_mode_i  (ne_mode),
        .ignore_i   (ignore_err),
        .irq_ack_i  (irq_ack),
        .run_o      (run),
        .freeze_o   (freeze),
        .trap_o     (trap)
    );

endmodule

// File: rtl/fpu_err_checker.sv
module fpu_err_checker #(
    parameter int NUM_EXC = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EXC-1:0] exc_mask,
    input logic               ne_mode,
    input logic               ignore_err,
    input logic               issue_vld,
    input logic [1:0]         issue_cls,
    input logic               irq_ack,
    input logic [NUM_EXC-1:0] flags,
    input logic               err_n,
    input logic               freeze,
    input logic               trap
);

    logic run_seen;
    assign run_seen = !freeze && !trap;

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_seen && issue_vld && issue_cls[1])
        |=> ((flags & $past(flags)) == $past(flags)));

    p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seen && issue_vld && issue_cls == 2'd2) |=> (flags == '0));

    p_quiet_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~exc_mask) == '0) |=> err_n);

    p_freeze_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |-> (!$past(ignore_err) && !$past(ne_mode)));

    p_nowait_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seen && issue_vld && issue_cls == 2'd1) |=> (!freeze && !trap));

    p_release_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze) |-> $past(irq_ack, 2));

    p_pin_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ne_mode |=> err_n);

    p_trap_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

endmodule

bind fpu_err_freeze_ctrl fpu_err_checker #(.NUM_EXC(NUM_EXC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_mask   (exc_mask),
    .ne_mode    (ne_mode),
    .ignore_err (ignore_err),
    .issue_vld  (issue_vld),
    .issue_cls  (issue_cls),
    .irq_ack    (irq_ack),
    .flags      (flags),
    .err_n      (err_n),
    .freeze     (freeze),
    .trap       (trap)
);

// File: tb/fpu_err_freeze_ctrl_test.sv
module fpu_err_freeze_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int WATCHDOG   = 5000;

    localparam int K_FLG = 0;
    localparam int K_ERR = 1;
    localparam int K_FRZ = 2;
    localparam int K_TRP = 3;

    typedef struct {
        int           due;
        int           kind;
        logic [N-1:0] val;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] exc_raise = '0;
    logic [N-1:0] exc_mask = '1;
    logic [N-1:0] err_timing = '0;
    logic         ne_mode = 1'b0;
    logic         ignore_err = 1'b0;
    logic         issue_vld = 1'b0;
    logic [1:0]   issue_cls = 2'd0;
    logic [N-1:0] restore_flags = '0;
    logic         irq_ack = 1'b0;
    logic [N-1:0] flags;
    logic         err_n;
    logic         freeze;
    logic         trap;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    item_t sb[$];

    fpu_err_freeze_ctrl #(.NUM_EXC(N)) uut (
        .clk(clk), .rst_n(rst_n), .exc_raise(exc_raise), .exc_mask(exc_mask),
        .err_timing(err_timing), .ne_mode(ne_mode), .ignore_err(ignore_err),
        .issue_vld(issue_vld), .issue_cls(issue_cls),
        .restore_flags(restore_flags), .irq_ack(irq_ack), .flags(flags),
        .err_n(err_n), .freeze(freeze), .trap(trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push_exp(input int d, input int kind, input logic [N-1:0] v,
                            input string tag);
        item_t it;
        it.due = cyc + d; it.kind = kind; it.val = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue_on(input logic [1:0] c);
        issue_vld = 1'b1;
        issue_cls = c;
    endtask

    // Monitor: compares each expected item in its due cycle, between edges.
    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < sb.size(); ) begin
                if (sb[i].due == cyc) begin
                    logic [N-1:0] act;
                    case (sb[i].kind)
                        K_FLG:   act = flags;
                        K_ERR:   act = {{(N-1){1'b0}}, err_n};
                        K_FRZ:   act = {{(N-1){1'b0}}, freeze};
                        default: act = {{(N-1){1'b0}}, trap};
                    endcase
                    n_checks++;
                    if (act !== sb[i].val) begin
                        n_errors++;
                        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                                 sb[i].tag, sb[i].kind, cyc, act, sb[i].val);
                    end
                    sb.delete(i);
                end else begin
                    i++;
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset values
        rst_n = 1'b1;
        push_exp(1, K_FLG, 6'h00, "R1"); push_exp(1, K_ERR, 6'h01, "R1");
        push_exp(1, K_FRZ, 6'h00, "R1"); push_exp(1, K_TRP, 6'h00, "R1");
        tick();

        // R2/R5: all masked, flags accumulate and stick
        exc_raise = 6'b000101;
        push_exp(1, K_FLG, 6'h05, "R2"); push_exp(2, K_ERR, 6'h01, "R5");
        tick(); exc_raise = '0;
        issue_on(2'd1);
        push_exp(1, K_FLG, 6'h05, "R2"); push_exp(1, K_FRZ, 6'h00, "R5");
        tick();
        issue_on(2'd0);
        push_exp(1, K_FLG, 6'h05, "R2"); push_exp(1, K_FRZ, 6'h00, "R5");
        push_exp(2, K_ERR, 6'h01, "R5");
        tick(); issue_vld = 1'b0;

        // R3: clear beats a same-cycle raise
        exc_raise = 6'b000010; issue_on(2'd2);
        push_exp(1, K_FLG, 6'h00, "R3");
        tick(); exc_raise = '0; issue_vld = 1'b0;

        // R4: restore loads, raises then accumulate
        restore_flags = 6'b100010; issue_on(2'd3);
        push_exp(1, K_FLG, 6'h22, "R4");
        tick(); issue_vld = 1'b0;
        exc_raise = 6'b000001;
        push_exp(1, K_FLG, 6'h23, "R4");
        tick(); exc_raise = '0;
        issue_on(2'd2); tick(); issue_vld = 1'b0;

        // R6: immediate pin
        exc_mask = 6'b111110; exc_raise = 6'b000001;
        push_exp(1, K_FLG, 6'h01, "R6"); push_exp(1, K_ERR, 6'h01, "R6");
        push_exp(2, K_ERR, 6'h00, "R6");
        tick(); exc_raise = '0; tick();

        // R9: no-wait never stalls
        issue_on(2'd1);
        push_exp(1, K_FRZ, 6'h00, "R9"); push_exp(1, K_TRP, 6'h00, "R9");
        tick();

        // R8: waiting issue freezes
        issue_on(2'd0);
        push_exp(1, K_FRZ, 6'h01, "R8");
        tick();

        // R11: issues ignored while frozen, release after ack
        issue_on(2'd2);
        push_exp(1, K_FLG, 6'h01, "R11"); push_exp(1, K_FRZ, 6'h01, "R11");
        tick(); issue_vld = 1'b0;
        for (int k = 0; k < 3; k++) begin
            push_exp(1, K_FRZ, 6'h01, "R11");
            tick();
        end
        irq_ack = 1'b1;
        push_exp(1, K_FRZ, 6'h01, "R11"); push_exp(2, K_FRZ, 6'h00, "R11");
        tick(); irq_ack = 1'b0; tick();

        // R12: clear drops the pin one edge later
        issue_on(2'd2);
        push_exp(1, K_FLG, 6'h00, "R12"); push_exp(1, K_ERR, 6'h00, "R12");
        push_exp(2, K_ERR, 6'h01, "R12");
        tick(); issue_vld = 1'b0; tick();

        // R7: deferred pin waits for the waiting issue
        exc_mask = 6'b111011; err_timing = 6'b000100; exc_raise = 6'b000100;
        push_exp(2, K_ERR, 6'h01, "R7");
        tick(); exc_raise = '0;
        push_exp(1, K_ERR, 6'h01, "R7");
        tick();
        issue_on(2'd0);
        push_exp(1, K_ERR, 6'h00, "R7"); push_exp(1, K_FRZ, 6'h01, "R8");
        tick(); issue_vld = 1'b0;
        irq_ack = 1'b1;
        push_exp(2, K_FRZ, 6'h00, "R11");
        tick(); irq_ack = 1'b0; tick();
        restore_flags = '0; issue_on(2'd3);
        push_exp(1, K_FLG, 6'h00, "R4"); push_exp(2, K_ERR, 6'h01, "R12");
        tick(); issue_vld = 1'b0; tick();
        err_timing = '0;

        // R10: ignore input bypasses freeze and pin
        ignore_err = 1'b1; exc_mask = 6'b110111; exc_raise = 6'b001000;
        push_exp(2, K_ERR, 6'h01, "R10");
        tick(); exc_raise = '0; tick();
        issue_on(2'd0);
        push_exp(1, K_FRZ, 6'h00, "R10"); push_exp(1, K_ERR, 6'h01, "R10");
        tick(); issue_vld = 1'b0;
        ignore_err = 1'b0;
        push_exp(1, K_ERR, 6'h00, "R6");
        tick();
        issue_on(2'd2);
        push_exp(2, K_ERR, 6'h01, "R12");
        tick(); issue_vld = 1'b0; tick();

        // R13: internal trap mode
        ne_mode = 1'b1; exc_mask = 6'b101111; exc_raise = 6'b010000;
        push_exp(2, K_ERR, 6'h01, "R13");
        tick(); exc_raise = '0; tick();
        issue_on(2'd0);
        push_exp(1, K_TRP, 6'h01, "R13"); push_exp(1, K_FRZ, 6'h00, "R13");
        push_exp(2, K_TRP, 6'h00, "R13"); push_exp(2, K_ERR, 6'h01, "R13");
        tick(); issue_vld = 1'b0; tick();
        issue_on(2'd2); tick(); issue_vld = 1'b0;
        ne_mode = 1'b0;

        repeat (4) tick();
        if (sb.size() != 0) begin
            n_checks++; n_errors++;
            $display("FAIL scoreboard left=%0d expected=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule